// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces a pair of complementary reset signals, one active-high and one active-low, for a system built around a processor. Reset is asserted from any of four causes: a supply-good flag from an external voltage comparator going low, a manual reset applied from outside on either reset pin, the internal reset timeout still running, or a watchdog that sees no activity on a serial data line. Each reset pin is an open-drain pad. The block drives it through a drive-enable output and reads the pad level back through a sense input. The same pin can therefore be pulled by an outside source, such as a push-button or another chip.

After any cause ends, reset stays asserted for a fixed number of clock cycles. Every timeout is a parameter counted in clock cycles, so short values can be used at test time. A memory-disable flag tells a companion memory interface to ignore accesses. It stays set while reset is active or while either pad sits at its active level. The watchdog can be left out of the build through a parameter.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While the filtered supply-good flag is low, and during the synchronous reset `rst`, both `rst_hi_drive_o` and `rst_lo_drive_o` are 1.
- R2: When the filtered supply-good flag rises, both drives stay at 1 for exactly `PUR_CYC` further cycles and then drop to 0.
- R3: `vdd_ok_i` passes through a two-flop synchronizer. A change of the synchronized level takes effect only after it has held for `GLITCH_CYC` consecutive cycles. A low pulse shorter than that has no effect on the drives.
- R4: A fall of `vdd_ok_i` that lasts long enough asserts both drives after exactly `GLITCH_CYC`+2 rising clock edges, with no added timeout.
- R5: A manual trigger restarts the `PUR_CYC` timeout on both outputs. A manual trigger is either a falling edge on `rst_lo_sense_i` (active level 0) or a rising edge on `rst_hi_sense_i` (active level 1), seen while the block is not driving.
- R6: A manual reset gives a pulse of fixed length. The drives release after `PUR_CYC` cycles even while the pad is still held active. Sensed edges that occur while the block drives the pads start no new timeout.
- R7: If the synchronized data line `sda_i` shows no transition for `WDT_CYC` cycles while reset is inactive, the watchdog fires. The firing starts a `PUR_CYC` reset on both drives.
- R8: Any transition of `sda_i`, rising or falling, clears the watchdog count. A line that toggles more often than every `WDT_CYC` cycles never causes a reset.
- R9: While reset is active, the watchdog count is held at zero. After a reset releases, a full `WDT_CYC` idle cycles are needed before the watchdog fires again.
- R10: `mem_disable_o` is 1 while reset is active, while `rst_lo_sense_i` is 0, or while `rst_hi_sense_i` is 1. This includes a pad held by an outside source after the internal timeout has ended.
- R11: With `WDT_EN`=0 there is no watchdog, and an idle data line never asserts reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_ok_i | input | 1 | Supply-good flag from the external comparator (asynchronous) |
| sda_i | input | 1 | Serial data line watched for activity (asynchronous) |
| rst_lo_sense_i | input | 1 | Sensed level of the active-low reset pad |
| rst_hi_sense_i | input | 1 | Sensed level of the active-high reset pad |
| rst_lo_drive_o | output | 1 | Pull-low enable for the active-low reset pad |
| rst_hi_drive_o | output | 1 | Pull-high enable for the active-high reset pad |
| mem_disable_o | output | 1 | Tells the companion memory interface to ignore accesses |

## Verification
A timeout counter left in the wrong state shows up at the drive outputs within one cycle. The release comes early or late against the `PUR_CYC` count taken from the last cause. A wrong filter count moves the reset assertion away from its `GLITCH_CYC`+2 edge, or lets a short supply pulse through. A watchdog that is not held cleared fires less than `WDT_CYC` cycles after a release. Stale sensed-pad history either restarts the timeout while the block drives the pads, or misses a manual edge. Both errors show up in the pulse length within `PUR_CYC` cycles.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Width needed to hold a count from 0 up to n.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Pad levels normalised so that 1 means "at active level".
    typedef struct packed {
        logic lo_low;   // active-low pad pulled to 0
        logic hi_high;  // active-high pad pulled to 1
    } pin_lvl_t;

endpackage

// File: rtl/supv_supply_filter.sv
module supv_supply_filter
    import supv_pkg::*;
#(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic vdd_ok_i,
    output logic vok_o
);
    localparam int FW = cnt_w(GLITCH_CYC);
    localparam logic [FW-1:0] RUN_LAST = FW'(GLITCH_CYC - 1);

    logic [1:0]    sync_q;
    logic          vok_q;
    logic [FW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            vok_q  <= 1'b0;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], vdd_ok_i};
            if (sync_q[1] == vok_q) begin
                run_q <= '0;
            end else if (run_q == RUN_LAST) begin
                vok_q <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign vok_o = vok_q;

    // R3: the filtered level only moves after a full run of agreeing samples
    p_glitch_run_r3: assert property (@(posedge clk) disable iff (rst)
        (vok_q != $past(vok_q)) |-> ($past(run_q) == RUN_LAST));

endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
    import supv_pkg::*;
#(
    parameter int WDT_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic sda_i,
    input  logic hold_i,
    output logic fire_o
);
    localparam int WW = cnt_w(WDT_CYC);
    localparam logic [WW-1:0] IDLE_LAST = WW'(WDT_CYC - 1);

    logic [2:0]    hist_q;
    logic [WW-1:0] idle_q;
    logic          toggle;
    logic          at_last;

    assign toggle  = hist_q[1] ^ hist_q[2];
    assign at_last = (idle_q == IDLE_LAST);
    assign fire_o  = !hold_i && !toggle && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 3'b111;
            idle_q <= '0;
        end else begin
            hist_q <= {hist_q[1:0], sda_i};
            if (hold_i || toggle || at_last) begin
                idle_q <= '0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    // R9: an active reset leaves the idle count cleared
    p_held_clear_r9: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (idle_q == '0));

    // R7: the idle count never passes the timeout value
    p_idle_bound_r7: assert property (@(posedge clk) disable iff (rst)
        idle_q <= IDLE_LAST);

    // R8: a seen transition restarts the idle count
    p_toggle_clears_r8: assert property (@(posedge clk) disable iff (rst)
        toggle |=> (idle_q == '0));

endmodule

// File: rtl/supv_manual_edge.sv
module supv_manual_edge
    import supv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_lvl_t lvl_i,
    input  logic     driving_i,
    output logic     trig_o
);
    pin_lvl_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign trig_o = !driving_i &&
                    ((lvl_i.lo_low  && !prev_q.lo_low) ||
                     (lvl_i.hi_high && !prev_q.hi_high));

endmodule

// File: rtl/supv_timer.sv
module supv_timer
    import supv_pkg::*;
#(
    parameter int PUR_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic vok_i,
    input  logic trig_i,
    output logic active_o
);
    localparam int TW = cnt_w(PUR_CYC);
    localparam logic [TW-1:0] FULL = TW'(PUR_CYC);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= FULL;
        end else if (!vok_i || trig_i) begin
            left_q <= FULL;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active_o = !vok_i || (left_q != '0);

    // R6: an untriggered timeout runs down one step per cycle
    p_fixed_len_r6: assert property (@(posedge clk) disable iff (rst)
        (vok_i && !trig_i && left_q != '0) |=> (left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
    import supv_pkg::*;
#(
    parameter int GLITCH_CYC = 4,
    parameter int PUR_CYC    = 20,
    parameter int WDT_CYC    = 50,
    parameter bit WDT_EN     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic vdd_ok_i,
    input  logic sda_i,
    input  logic rst_lo_sense_i,
    input  logic rst_hi_sense_i,
    output logic rst_lo_drive_o,
    output logic rst_hi_drive_o,
    output logic mem_disable_o
);
    logic     vok_f;
    logic     active;
    logic     man_trig;
    logic     wdt_fire;
    pin_lvl_t pad_lvl;

    assign pad_lvl.lo_low  = !rst_lo_sense_i;
    assign pad_lvl.hi_high = rst_hi_sense_i;

    supv_supply_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .vdd_ok_i (vdd_ok_i),
        .vok_o    (vok_f)
    );

    supv_manual_edge u_manual (
        .clk       (clk),
        .rst       (rst),
        .lvl_i     (pad_lvl),
        .driving_i (active),
        .trig_o    (man_trig)
    );

    generate
        if (WDT_EN) begin : g_wdt
            supv_watchdog #(.WDT_CYC(WDT_CYC)) u_wdt (
                .clk    (clk),
                .rst    (rst),
                .sda_i  (sda_i),
                .hold_i (active),
                .fire_o (wdt_fire)
            );
        end else begin : g_no_wdt
            assign wdt_fire = 1'b0;
        end
    endgenerate

    supv_timer #(.PUR_CYC(PUR_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .vok_i    (vok_f),
        .trig_i   (man_trig || wdt_fire),
        .active_o (active)
    );

    assign rst_lo_drive_o = active;
    assign rst_hi_drive_o = active;
    assign mem_disable_o  = active || pad_lvl.lo_low || pad_lvl.hi_high;

    // R1: a low filtered supply drives both pads
    p_supply_low_r1: assert property (@(posedge clk) disable iff (rst)
        !vok_f |-> (rst_lo_drive_o && rst_hi_drive_o));

    // R4: a filtered supply fall shows on the pads in the same cycle
    p_fall_direct_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(vok_f) |-> (rst_lo_drive_o && rst_hi_drive_o));

    // R10: an outside-held active-low pad keeps memory disabled
    p_memdis_pad_r10: assert property (@(posedge clk) disable iff (rst)
        (!rst_lo_sense_i || rst_hi_sense_i) |-> mem_disable_o);

    // R6: a trigger is never taken while the pads are being driven
    p_no_self_trig_r6: assert property (@(posedge clk) disable iff (rst)
        rst_lo_drive_o |-> !man_trig);

endmodule

// File: tb/supv_reset_ctrl_bench.sv
module supv_reset_ctrl_bench;
    localparam int G = 4;
    localparam int P = 20;
    localparam int W = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vdd_ok = 1'b0;
    logic sda = 1'b1;
    logic ext_lo = 1'b0;
    logic ext_hi = 1'b0;
    logic sda_run = 1'b0;
    logic cmp_en = 1'b0;

    logic drv_lo, drv_hi, mem_dis;
    logic lo_sense, hi_sense;
    logic nw_drv_lo, nw_drv_hi, nw_mem;
    logic nw_lo_sense, nw_hi_sense;

    int n_vec = 0;
    int n_bad = 0;
    string phase_req = "R1";

    always #2 clk = ~clk;

    assign lo_sense    = !(drv_lo || ext_lo);
    assign hi_sense    = drv_hi || ext_hi;
    assign nw_lo_sense = !nw_drv_lo;
    assign nw_hi_sense = nw_drv_hi;

    supv_reset_ctrl #(.GLITCH_CYC(G), .PUR_CYC(P), .WDT_CYC(W), .WDT_EN(1'b1)) u_supv_reset_ctrl (
        .clk(clk), .rst(rst), .vdd_ok_i(vdd_ok), .sda_i(sda),
        .rst_lo_sense_i(lo_sense), .rst_hi_sense_i(hi_sense),
        .rst_lo_drive_o(drv_lo), .rst_hi_drive_o(drv_hi), .mem_disable_o(mem_dis)
    );

    supv_reset_ctrl #(.GLITCH_CYC(G), .PUR_CYC(P), .WDT_CYC(W), .WDT_EN(1'b0)) u_nowd (
        .clk(clk), .rst(rst), .vdd_ok_i(vdd_ok), .sda_i(sda),
        .rst_lo_sense_i(nw_lo_sense), .rst_hi_sense_i(nw_hi_sense),
        .rst_lo_drive_o(nw_drv_lo), .rst_hi_drive_o(nw_drv_hi), .mem_disable_o(nw_mem)
    );

    // ---------------- behavioural reference ----------------
    int vq[$];        // supply samples, newest first
    int sq[$];        // data-line samples, newest first
    int m_vok, m_run, m_left, m_idle;
    int m_lo_prev, m_hi_prev;

    function automatic int m_active();
        return (m_vok == 0 || m_left > 0) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            vq = '{0, 0};
            sq = '{1, 1, 1};
            m_vok = 0; m_run = 0; m_left = P; m_idle = 0;
            m_lo_prev = 0; m_hi_prev = 0;
        end else begin
            int act, lo_now, hi_now, man, tog, fire, vdel;
            act    = m_active();
            lo_now = (act != 0 || ext_lo) ? 1 : 0;
            hi_now = (act != 0 || ext_hi) ? 1 : 0;
            man    = (act == 0 && ((lo_now == 1 && m_lo_prev == 0) ||
                                   (hi_now == 1 && m_hi_prev == 0))) ? 1 : 0;
            tog    = (sq[1] != sq[2]) ? 1 : 0;
            fire   = (act == 0 && tog == 0 && m_idle == W - 1) ? 1 : 0;
            vdel   = vq[1];
            // timer uses the pre-edge supply state
            if (m_vok == 0 || man == 1 || fire == 1) m_left = P;
            else if (m_left > 0) m_left = m_left - 1;
            if (act == 1 || tog == 1 || m_idle == W - 1) m_idle = 0;
            else m_idle = m_idle + 1;
            if (vdel != m_vok) begin
                m_run = m_run + 1;
                if (m_run == G) begin m_vok = vdel; m_run = 0; end
            end else begin
                m_run = 0;
            end
            m_lo_prev = lo_now;
            m_hi_prev = hi_now;
            vq.push_front(int'(vdd_ok)); void'(vq.pop_back());
            sq.push_front(int'(sda));    void'(sq.pop_back());
        end
    end

    task automatic check(string req, logic got, logic exp, string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            logic e_act, e_mem;
            e_act = (m_active() != 0);
            e_mem = e_act || ext_lo || ext_hi;
            check(phase_req, drv_lo,  e_act, "model lo drive");
            check(phase_req, drv_hi,  e_act, "model hi drive");
            check(phase_req, mem_dis, e_mem, "model mem disable");
        end
    end

    // data-line activity generator
    initial begin
        int k = 0;
        forever begin
            @(negedge clk); #1;
            if (sda_run) begin
                k++;
                if (k % 10 == 0) sda = ~sda;
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog on the run itself
    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        wait_cyc(4);
        check("R1", drv_lo, 1'b1, "lo drive in reset");
        check("R1", drv_hi, 1'b1, "hi drive in reset");
        #1 rst = 1'b0;
        cmp_en = 1'b1;
        wait_cyc(10);
        check("R1", drv_lo, 1'b1, "lo drive, supply low");

        // R2: power-up timeout
        phase_req = "R2";
        #1 vdd_ok = 1'b1; sda_run = 1'b1;
        wait_cyc(10);
        check("R2", drv_hi, 1'b1, "hi drive inside power-up timeout");
        wait_cyc(30);
        check("R2", drv_lo, 1'b0, "lo drive after power-up timeout");

        // R3: short supply dip is ignored
        phase_req = "R3";
        #1 vdd_ok = 1'b0;
        wait_cyc(G - 1);
        #1 vdd_ok = 1'b1;
        wait_cyc(12);
        check("R3", drv_lo, 1'b0, "lo drive after short dip");

        // R4: long dip asserts after G+2 edges
        phase_req = "R4";
        #1 vdd_ok = 1'b0;
        wait_cyc(G + 1);
        check("R4", drv_lo, 1'b0, "lo drive one edge before filter");
        wait_cyc(1);
        check("R4", drv_lo, 1'b1, "lo drive at filter edge");
        wait_cyc(4);
        #1 vdd_ok = 1'b1;
        wait_cyc(40);
        check("R2", drv_lo, 1'b0, "lo drive released after recovery");

        // R5/R6/R10: held active-low pad
        phase_req = "R5";
        #1 ext_lo = 1'b1;
        wait_cyc(3);
        check("R5", drv_hi, 1'b1, "hi drive after low-pad edge");
        phase_req = "R6";
        wait_cyc(30);
        check("R6", drv_lo, 1'b0, "lo drive released while pad held");
        check("R10", mem_dis, 1'b1, "mem disable with held pad");
        wait_cyc(30);
        check("R6", drv_lo, 1'b0, "no retrigger while pad held");
        phase_req = "R10";
        #1 ext_lo = 1'b0;
        wait_cyc(2);
        check("R10", mem_dis, 1'b0, "mem disable after pad release");

        // R5/R6: active-high pad pulses, second during drive
        phase_req = "R5";
        #1 ext_hi = 1'b1;
        wait_cyc(1);
        #1 ext_hi = 1'b0;
        wait_cyc(2);
        check("R5", drv_lo, 1'b1, "lo drive after high-pad edge");
        phase_req = "R6";
        wait_cyc(7);
        #1 ext_hi = 1'b1;
        wait_cyc(1);
        #1 ext_hi = 1'b0;
        wait_cyc(15);
        check("R6", drv_lo, 1'b0, "edge during drive ignored");

        // R7/R9: watchdog timeout from one known transition
        phase_req = "R7";
        #1 sda_run = 1'b0;
        wait_cyc(12);
        #1 sda = ~sda;
        wait_cyc(45);
        check("R7", drv_lo, 1'b0, "before watchdog period");
        wait_cyc(15);
        check("R7", drv_lo, 1'b1, "after watchdog period");
        phase_req = "R9";
        wait_cyc(40);
        check("R9", drv_lo, 1'b0, "released after watchdog reset");
        wait_cyc(18);
        check("R9", drv_lo, 1'b0, "watchdog restarted from zero");
        wait_cyc(12);
        check("R9", drv_lo, 1'b1, "second watchdog firing");

        // R8: steady activity keeps reset away
        phase_req = "R8";
        #1 sda_run = 1'b1;
        wait_cyc(30);
        for (int i = 0; i < 6; i++) begin
            wait_cyc(50);
            check("R8", drv_lo, 1'b0, "active data line");
        end

        // R11: build without watchdog
        phase_req = "R7";
        #1 sda_run = 1'b0;
        wait_cyc(120);
        check("R11", nw_drv_lo, 1'b0, "no watchdog build, lo drive");
        check("R11", nw_mem, 1'b0, "no watchdog build, mem disable");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule